// File: doc/BRIEF.md
# Repeat-Prefix String Operation Sequencer

This block sits beside the instruction decoder and controls how many times a single string-style operation runs. It watches a byte-wide stream of prefix and opcode bytes. Prefix bytes choose a repeat mode and can request a bus lock. The first byte that is not a prefix starts the instruction. The block then steps the datapath through the operation. Before each pass it tests the count register, and it stops after a pass on the zero flag when a conditional mode is in force. The datapath handles the data movement, memory access and decrementing of the count register, driven by the issue and decrement strobes that this block produces.

The controller is a five-state machine. **IDLE** takes prefix bytes and waits for an opcode. **TEST** checks whether the count is zero. **ISSUE** sends one pass to the datapath. **WAIT** holds until the datapath reports that the pass has finished. **FINISH** pulses done and clears the prefix state. The transitions are:
- IDLE→ISSUE on an opcode with no repeat prefix.
- IDLE→TEST on an opcode with a repeat prefix.
- TEST→FINISH when the count is zero.
- TEST→ISSUE when the count is nonzero.
- ISSUE→WAIT always.
- WAIT→TEST when the pass result is in and the stop rule does not fire.
- WAIT→FINISH when the pass result is in and the stop rule fires.
- FINISH→IDLE always.

Top module: `rps_seq`

## Requirements
- R1: After reset, `issue`, `cnt_dec`, `lock_req` and `done` are all low and the block is idle.
- R2: In IDLE the block recognises these prefix codes: 0xE1 (repeat on count only), 0xE2 (repeat while zero flag clear), 0xE3 (repeat while zero flag set) and 0xE4 (lock). Any other byte is an opcode. When several repeat prefixes arrive, the last one sets the mode. A lock prefix combines with any repeat prefix. Bytes that arrive while an instruction is in progress have no effect on it or on the next instruction. No output is raised while prefix bytes are being taken.
- R3: An opcode with no repeat prefix produces exactly one `issue` pulse and no `cnt_dec`. `done` follows the pass result.
- R4: With a repeat prefix and a count of zero, `issue` is never raised. `done` is high in the second cycle after the cycle in which the opcode was sampled.
- R5: Mode 0xE1 issues exactly N passes for a starting count N, then raises done.
- R6: Mode 0xE2 stops after the first pass that returns the zero flag set, or when the count runs out, whichever comes first.
- R7: Mode 0xE3 stops after the first pass that returns the zero flag clear, or when the count runs out, whichever comes first.
- R8: With a lock prefix, `lock_req` is high from the first cycle after the opcode is taken until the cycle before `done`. It is low in the `done` cycle, and it stays low for an instruction without a lock prefix.
- R9: All prefix state clears when `done` is raised. An instruction that follows with no prefixes behaves as unprefixed.
- R10: `issue` lasts one cycle. A new pass is never issued until the datapath has acknowledged the previous one.
- R11: `cnt_dec` is raised in the same cycle as each `issue` under a repeat mode, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_vld | input | 1 | Byte on `op_byte` is valid |
| op_byte | input | 8 | Prefix or opcode byte |
| cnt_in | input | CNT_W | Current value of the count register |
| zf_in | input | 1 | Zero flag of the pass just finished, sampled with `iter_ack` |
| iter_ack | input | 1 | Datapath has finished the issued pass |
| issue | output | 1 | Start one pass of the operation |
| cnt_dec | output | 1 | Decrement the count register by one |
| lock_req | output | 1 | Hold the bus for the locked instruction |
| done | output | 1 | One-cycle pulse: the instruction has finished |

## Verification
The bench builds the block with the default 32-bit count width and the default prefix codes. With a full-width count it can start a conditional repeat from a count near 2^32 and show that the zero-flag rule alone ends it after a few passes. Counts of zero and small counts cover the pre-test and exhaustion paths. Stray bytes, including prefix codes, are sent during busy cycles and must have no effect.

// File: rtl/rps_pkg.sv
package rps_pkg;

    typedef enum logic [1:0] {
        RPT_NONE,
        RPT_ALWAYS,
        RPT_WHILE_NZ,
        RPT_WHILE_Z
    } rpt_mode_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_TEST,
        S_ISSUE,
        S_WAIT,
        S_FINISH
    } seq_state_e;

    typedef struct packed {
        rpt_mode_e mode;
        logic      lock;
    } pfx_t;

endpackage

// File: rtl/rps_prefix_decode.sv
module rps_prefix_decode #(
    parameter logic [7:0] CODE_RPT    = 8'hE1,
    parameter logic [7:0] CODE_RPT_NZ = 8'hE2,
    parameter logic [7:0] CODE_RPT_Z  = 8'hE3,
    parameter logic [7:0] CODE_LOCK   = 8'hE4
) (
    input  logic       byte_vld,
    input  logic [7:0] byte_val,
    output logic       hit_rpt,
    output logic       hit_rpt_nz,
    output logic       hit_rpt_z,
    output logic       hit_lock,
    output logic       hit_opcode
);
    logic any_pfx;

    always_comb begin
        hit_rpt    = byte_vld && (byte_val == CODE_RPT);
        hit_rpt_nz = byte_vld && (byte_val == CODE_RPT_NZ);
        hit_rpt_z  = byte_vld && (byte_val == CODE_RPT_Z);
        hit_lock   = byte_vld && (byte_val == CODE_LOCK);
        any_pfx    = hit_rpt || hit_rpt_nz || hit_rpt_z || hit_lock;
        hit_opcode = byte_vld && !any_pfx;
    end

endmodule

// File: rtl/rps_prefix_latch.sv
module rps_prefix_latch
    import rps_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic idle,
    input  logic clear,
    input  logic hit_rpt,
    input  logic hit_rpt_nz,
    input  logic hit_rpt_z,
    input  logic hit_lock,
    output pfx_t pfx
);
    pfx_t pfx_nxt;

    always_comb begin
        pfx_nxt = pfx;
        if (clear) begin
            pfx_nxt.mode = RPT_NONE;
            pfx_nxt.lock = 1'b0;
        end else if (idle) begin
            if (hit_rpt)    pfx_nxt.mode = RPT_ALWAYS;
            if (hit_rpt_nz) pfx_nxt.mode = RPT_WHILE_NZ;
            if (hit_rpt_z)  pfx_nxt.mode = RPT_WHILE_Z;
            if (hit_lock)   pfx_nxt.lock = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pfx.mode <= RPT_NONE;
            pfx.lock <= 1'b0;
        end else begin
            pfx <= pfx_nxt;
        end
    end

    // R9: prefix state is empty after the finishing cycle
    p_clear_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (pfx.mode == RPT_NONE && !pfx.lock));

    // R2: nothing changes the prefix state while an instruction is in progress
    p_busy_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !clear) |=> $stable(pfx));

endmodule

// File: rtl/rps_term_eval.sv
module rps_term_eval
    import rps_pkg::*;
(
    input  rpt_mode_e mode,
    input  logic      zf,
    output logic      stop_after_pass
);
    always_comb begin
        unique case (mode)
            RPT_NONE:     stop_after_pass = 1'b1;
            RPT_ALWAYS:   stop_after_pass = 1'b0;
            RPT_WHILE_NZ: stop_after_pass = zf;
            RPT_WHILE_Z:  stop_after_pass = !zf;
            default:      stop_after_pass = 1'b1;
        endcase
    end

endmodule

// File: rtl/rps_seq_fsm.sv
module rps_seq_fsm
    import rps_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  pfx_t       pfx,
    input  logic       cnt_zero,
    input  logic       iter_ack,
    input  logic       stop_after_pass,
    output seq_state_e state,
    output logic       issue,
    output logic       cnt_dec,
    output logic       lock_req,
    output logic       done
);
    seq_state_e state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE:   if (start) state_nxt = (pfx.mode == RPT_NONE) ? S_ISSUE : S_TEST;
            S_TEST:   state_nxt = cnt_zero ? S_FINISH : S_ISSUE;
            S_ISSUE:  state_nxt = S_WAIT;
            S_WAIT:   if (iter_ack) state_nxt = stop_after_pass ? S_FINISH : S_TEST;
            S_FINISH: state_nxt = S_IDLE;
            default:  state_nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        issue    = 1'b0;
        cnt_dec  = 1'b0;
        lock_req = 1'b0;
        done     = 1'b0;
        unique case (state)
            S_IDLE: ;
            S_TEST: lock_req = pfx.lock;
            S_ISSUE: begin
                issue    = 1'b1;
                cnt_dec  = (pfx.mode != RPT_NONE);
                lock_req = pfx.lock;
            end
            S_WAIT:   lock_req = pfx.lock;
            S_FINISH: done = 1'b1;
            default: ;
        endcase
    end

    // R11: a decrement only ever comes with an issued pass
    p_dec_with_issue_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_dec |-> issue);

    // R3: an unprefixed instruction never decrements the count
    p_no_dec_unprefixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pfx.mode == RPT_NONE) |-> !cnt_dec);

    // R10: issue is a single-cycle strobe
    p_issue_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> !issue);

    // R4: a zero count seen at the test ends the instruction next cycle
    p_zero_count_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_TEST && cnt_zero) |=> (done && !issue));

    // R8: the lock is released on the done cycle
    p_lock_off_at_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !lock_req);

    // R8: a locked instruction keeps its lock while a pass is outstanding
    p_lock_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_req && !iter_ack && state == S_WAIT) |=> lock_req);

endmodule

// File: rtl/rps_seq.sv
module rps_seq
    import rps_pkg::*;
#(
    parameter int         CNT_W       = 32,
    parameter logic [7:0] CODE_RPT    = 8'hE1,
    parameter logic [7:0] CODE_RPT_NZ = 8'hE2,
    parameter logic [7:0] CODE_RPT_Z  = 8'hE3,
    parameter logic [7:0] CODE_LOCK   = 8'hE4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_vld,
    input  logic [7:0]       op_byte,
    input  logic [CNT_W-1:0] cnt_in,
    input  logic             zf_in,
    input  logic             iter_ack,
    output logic             issue,
    output logic             cnt_dec,
    output logic             lock_req,
    output logic             done
);
    logic       hit_rpt, hit_rpt_nz, hit_rpt_z, hit_lock, hit_opcode;
    logic       idle, start, cnt_zero, stop_after_pass;
    pfx_t       pfx;
    seq_state_e state;

    rps_prefix_decode #(
        .CODE_RPT    (CODE_RPT),
        .CODE_RPT_NZ (CODE_RPT_NZ),
        .CODE_RPT_Z  (CODE_RPT_Z),
        .CODE_LOCK   (CODE_LOCK)
    ) u_dec (
        .byte_vld   (op_vld),
        .byte_val   (op_byte),
        .hit_rpt    (hit_rpt),
        .hit_rpt_nz (hit_rpt_nz),
        .hit_rpt_z  (hit_rpt_z),
        .hit_lock   (hit_lock),
        .hit_opcode (hit_opcode)
    );

    assign idle     = (state == S_IDLE);
    assign start    = idle && hit_opcode;
    assign cnt_zero = (cnt_in == '0);

    rps_prefix_latch u_pfx (
        .clk        (clk),
        .rst_n      (rst_n),
        .idle       (idle),
        .clear      (done),
        .hit_rpt    (hit_rpt),
        .hit_rpt_nz (hit_rpt_nz),
        .hit_rpt_z  (hit_rpt_z),
        .hit_lock   (hit_lock),
        .pfx        (pfx)
    );

    rps_term_eval u_term (
        .mode            (pfx.mode),
        .zf              (zf_in),
        .stop_after_pass (stop_after_pass)
    );

    rps_seq_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .start           (start),
        .pfx             (pfx),
        .cnt_zero        (cnt_zero),
        .iter_ack        (iter_ack),
        .stop_after_pass (stop_after_pass),
        .state           (state),
        .issue           (issue),
        .cnt_dec         (cnt_dec),
        .lock_req        (lock_req),
        .done            (done)
    );

    // R1: nothing is driven while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !(issue || cnt_dec || lock_req || done));

endmodule

// File: tb/sim_rps_seq.sv
module sim_rps_seq;
    localparam int CW = 32;
    localparam logic [7:0] P_RPT = 8'hE1, P_NZ = 8'hE2, P_Z = 8'hE3, P_LK = 8'hE4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic op_vld = 1'b0, zf_in = 1'b0, iter_ack = 1'b0;
    logic [7:0] op_byte = 8'h00;
    logic [CW-1:0] cnt_reg = '0;
    logic issue, cnt_dec, lock_req, done;
    int n_vec = 0, n_bad = 0;

    always #5 clk = ~clk;

    rps_seq #(.CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .op_vld(op_vld), .op_byte(op_byte),
        .cnt_in(cnt_reg), .zf_in(zf_in), .iter_ack(iter_ack),
        .issue(issue), .cnt_dec(cnt_dec), .lock_req(lock_req), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // mode: 0 none, 1 count only, 2 while zero clear, 3 while zero set
    function automatic longint exp_passes(input int mode, input longint cnt, input bit [63:0] z);
        longint i = 0;
        if (mode == 0) return 1;
        while (i < cnt && i < 100000) begin
            i++;
            if (mode == 2 && z[(i-1) % 64]) break;
            if (mode == 3 && !z[(i-1) % 64]) break;
        end
        return i;
    endfunction

    function automatic logic [7:0] mode_code(input int mode);
        case (mode)
            1: return P_RPT;
            2: return P_NZ;
            default: return P_Z;
        endcase
    endfunction

    task automatic run_instr(input int mode, input bit lck, input longint cnt0,
                             input bit noise, input bit [63:0] z, input int decoy);
        logic [7:0] q[$];
        int k = 0, wait_d = 0, pass_idx = 0, pfx_bad = 0, lock_bad = 0;
        longint n_iss = 0, n_dec = 0, exp;
        string req;
        bit hung = 0;
        q = {};
        if (decoy != 0 && mode != 0) q.push_back(mode_code(decoy));
        if (lck && $urandom_range(1, 0) == 1) q.push_back(P_LK);
        if (mode != 0) q.push_back(mode_code(mode));
        if (lck && q.size() > 0 && q[0] != P_LK) q.push_back(P_LK);
        else if (lck && q.size() == 0) q.push_back(P_LK);
        q.push_back(8'h10 + 8'($urandom_range(8'hBF, 0)));
        cnt_reg = cnt0[CW-1:0];
        foreach (q[i]) begin
            @(negedge clk);
            if (issue || cnt_dec || lock_req || done) pfx_bad++;
            op_vld = 1'b1;
            op_byte = q[i];
        end
        @(negedge clk);
        op_vld = 1'b0;
        chk(pfx_bad == 0, "R2", "outputs active during prefix bytes", pfx_bad, 0);
        forever begin
            if (iter_ack) iter_ack = 1'b0;
            zf_in = 1'($urandom_range(1, 0));
            if (issue) begin
                n_iss++;
                wait_d = $urandom_range(3, 1);
            end else if (wait_d > 0) begin
                wait_d--;
                if (wait_d == 0) begin
                    iter_ack = 1'b1;
                    zf_in = z[pass_idx % 64];
                    pass_idx++;
                end
            end
            if (cnt_dec) begin
                n_dec++;
                cnt_reg = cnt_reg - 1'b1;
            end
            if (lock_req !== (lck && !done)) lock_bad++;
            if (done) begin
                op_vld = 1'b0;
                break;
            end
            if (noise) begin
                op_vld = 1'($urandom_range(1, 0));
                op_byte = ($urandom_range(1, 0) == 1) ? (8'hE1 + 8'($urandom_range(3, 0)))
                                                      : 8'($urandom_range(255, 0));
            end
            k++;
            if (k > 5000) begin hung = 1; break; end
            @(negedge clk);
        end
        op_vld = 1'b0;
        iter_ack = 1'b0;
        chk(!hung, "R10", "instruction completes", k, 0);
        exp = exp_passes(mode, cnt0, z);
        req = (mode == 0) ? "R3" : (mode == 1) ? "R5" : (mode == 2) ? "R6" : "R7";
        chk(n_iss == exp, req, "passes issued", n_iss, exp);
        chk(n_dec == ((mode == 0) ? 0 : exp), "R11", "decrements", n_dec, (mode == 0) ? 0 : exp);
        chk(lock_bad == 0, "R8", "lock_req mismatching cycles", lock_bad, 0);
        if (mode != 0 && cnt0 == 0)
            chk(k == 1, "R4", "zero-count done latency", k, 1);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R10 watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(!(issue || cnt_dec || lock_req || done), "R1", "outputs in reset",
            {issue, cnt_dec, lock_req, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!(issue || cnt_dec || lock_req || done), "R1", "outputs after reset",
            {issue, cnt_dec, lock_req, done}, 0);

        run_instr(0, 0, 7, 0, '0, 0);                       // R3 plain
        run_instr(1, 0, 0, 0, '0, 0);                       // R4 count only
        run_instr(2, 0, 0, 0, '1, 0);                       // R4 while clear
        run_instr(3, 1, 0, 0, '0, 0);                       // R4 + R8
        run_instr(1, 1, 5, 0, '0, 0);                       // R5 + R8
        run_instr(0, 0, 3, 0, '0, 0);                       // R9 prefix cleared
        run_instr(2, 0, 64'hFFFF_FFFF, 0, 64'h8, 0);        // R6 large count, 4 passes
        run_instr(3, 1, 64'hFFFF_FFFE, 0, ~64'h40, 0);      // R7 large count, 7 passes
        run_instr(2, 0, 3, 0, '0, 0);                       // R6 count runs out
        run_instr(3, 0, 4, 0, '1, 0);                       // R7 count runs out
        run_instr(1, 0, 6, 0, '1, 3);                       // R2 last repeat prefix wins
        run_instr(1, 1, 4, 1, '0, 0);                       // R2 bytes while busy
        run_instr(0, 0, 2, 0, '0, 0);                       // R2/R9 clean afterwards

        for (int n = 0; n < 60; n++) begin
            int m = $urandom_range(3, 0);
            bit [63:0] z = {$urandom(), $urandom()};
            longint c = $urandom_range(12, 0);
            int dec = ($urandom_range(3, 0) == 0) ? $urandom_range(3, 1) : 0;
            run_instr(m, 1'($urandom_range(1, 0)), c, 1'($urandom_range(1, 0)), z, dec);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule